// File: doc/BRIEF.md
# Supply and Manual Reset Supervisor

This block produces the system reset for a chip. It watches a digital under-voltage flag, which stands in for an analog supply comparator, and a shared manual-reset pin. That pin is both an input for a push button and the block's own active-low reset output. While the supply is low, reset stays asserted. Once the supply recovers, or after a manual trigger, reset stays asserted for a fixed timeout of `TIMEOUT_CYCLES` clocks and then releases.

The block drives two open-drain style enables. One pulls the active-low pin down. The other drives the active-high reset line up. Both are set only while reset is asserted, and pull resistors outside the block define the released level. The block also gives memory blocks on the chip an internal flag that blocks their access while reset is asserted.

Short dips on the supply flag and short low pulses on the pin are filtered out. The pin is edge-triggered, so holding it low does not extend reset. The block's own drive on the pin never re-arms the timer.

Top module: `supply_reset_supervisor`

## Requirements
- R1: While `rstN` is low, reset is asserted. After `rstN` rises, reset stays asserted for at least `TIMEOUT_CYCLES`-1 cycles and releases no later than `TIMEOUT_CYCLES`+2 cycles after the rise.
- R2: When `supplyLow` is 1 for `UV_FILTER` or more consecutive cycles, reset is asserted within `UV_FILTER`+2 cycles. Reset then stays asserted for as long as `supplyLow` stays 1.
- R3: A `supplyLow` pulse shorter than `UV_FILTER` cycles causes no reset.
- R4: After a qualified `supplyLow` returns to 0, reset stays asserted for at least `TIMEOUT_CYCLES`-1 cycles and releases no later than `TIMEOUT_CYCLES`+2 cycles after that return.
- R5: A high-to-low transition on `mrPinIn`, followed by a low level lasting at least `MR_FILTER` cycles, asserts reset within `MR_FILTER`+4 cycles of the falling edge.
- R6: A low pulse on `mrPinIn` shorter than `MR_FILTER` cycles is ignored.
- R7: A qualified manual pulse that ends before the timeout still holds reset asserted for at least `MR_FILTER`+`TIMEOUT_CYCLES`+1 cycles after the falling edge. Reset releases by `MR_FILTER`+`TIMEOUT_CYCLES`+5 cycles.
- R8: The manual input is edge-triggered. If the pin is held low past the timeout, reset releases on schedule. It is not asserted again until the pin goes high and then falls again.
- R9: After reset releases, the low level that the block itself drove onto the shared pin does not start a new timeout.
- R10: A qualified supply dip during a running timeout restarts the count. Release then follows R4, measured from the end of the dip.
- R11: `rstLowDrvEn` (1 = pull the active-low pin down) and `rstHighDrvEn` (1 = drive the active-high line up) are both equal to `resetActive` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low initialisation; the timeout starts when it is released |
| supplyLow | input | 1 | Under-voltage flag, 1 = supply below threshold |
| mrPinIn | input | 1 | Level read back from the shared manual-reset pin |
| rstLowDrvEn | output | 1 | 1 = pull the active-low reset pin to ground |
| rstHighDrvEn | output | 1 | 1 = drive the active-high reset line high |
| resetActive | output | 1 | Internal reset flag that blocks memory access |

## Verification
The bench targets the filter boundaries: supply and pin pulses one cycle shorter than their qualification length. A filter that is off by one would reset on these glitches. It drives the pin the way a wired pull-up would. Any design that sees its own low drive as a button press then stays in reset forever. It also holds the pin low far past the timeout, which catches a level-sensitive input that never releases. Finally, it injects a supply dip in the middle of a manual timeout. A design that does not clear the counter would release about half a timeout too early.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // control -> datapath
  typedef struct packed {
    logic clrTimer;
    logic runTimer;
    logic driving;
  } rsvStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic uvQual;
    logic mrTrig;
    logic timerDone;
  } rsvStatus_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } rsvState_t;

endpackage

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 200,
  parameter int unsigned UV_FILTER      = 4,
  parameter int unsigned MR_FILTER      = 6,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyLow,
  input  logic       pinIn,
  input  rsvStrobe_t strobe,
  output rsvStatus_t status
);

  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYCLES);
  localparam int unsigned UV_W  = $clog2(UV_FILTER + 1);
  localparam int unsigned MR_W  = $clog2(MR_FILTER + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);
  localparam logic [UV_W-1:0]  UV_LAST  = UV_W'(UV_FILTER - 1);
  localparam logic [UV_W-1:0]  UV_MAX   = UV_W'(UV_FILTER);
  localparam logic [MR_W-1:0]  MR_LAST  = MR_W'(MR_FILTER - 1);

  // pin synchroniser
  logic [SYNC_STAGES-1:0] pinSync;
  logic pinLowS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= '0;
    else       pinSync <= {pinSync[SYNC_STAGES-2:0], pinIn};
  end
  assign pinLowS = ~pinSync[SYNC_STAGES-1];

  // supply glitch filter
  logic [UV_W-1:0] uvCnt;
  logic uvQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvCnt  <= '0;
      uvQual <= 1'b0;
    end else if (supplyLow) begin
      uvCnt  <= (uvCnt == UV_MAX) ? uvCnt : uvCnt + UV_W'(1);
      uvQual <= uvQual | (uvCnt == UV_LAST);
    end else begin
      uvCnt  <= '0;
      uvQual <= 1'b0;
    end
  end

  // manual pin filter and falling-edge detect; own drive masks the pin
  logic [MR_W-1:0] mrCnt;
  logic mrLow;
  logic mrTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrCnt  <= MR_LAST;
      mrLow  <= 1'b1;
      mrTrig <= 1'b0;
    end else if (strobe.driving) begin
      mrCnt  <= MR_LAST;
      mrLow  <= 1'b1;
      mrTrig <= 1'b0;
    end else if (pinLowS) begin
      mrTrig <= ~mrLow & (mrCnt == MR_LAST);
      mrLow  <= mrLow | (mrCnt == MR_LAST);
      mrCnt  <= (mrCnt == MR_LAST) ? mrCnt : mrCnt + MR_W'(1);
    end else begin
      mrCnt  <= '0;
      mrLow  <= 1'b0;
      mrTrig <= 1'b0;
    end
  end

  // timeout counter
  logic [TMR_W-1:0] timerCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerCnt <= '0;
    else if (strobe.clrTimer) timerCnt <= '0;
    else if (strobe.runTimer) timerCnt <= timerCnt + TMR_W'(1);
  end

  assign status.uvQual    = uvQual;
  assign status.mrTrig    = mrTrig;
  assign status.timerDone = (timerCnt == TMR_LAST);

  AST_UV_QUAL_FILTERED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvQual) |-> (uvCnt == UV_MAX)); // R3

  AST_NO_SELF_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driving && $past(strobe.driving)) |-> !mrTrig); // R9

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timerCnt <= TMR_LAST); // R4

endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rsvStatus_t status,
  output rsvStrobe_t strobe
);

  rsvState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clrTimer = status.uvQual | status.mrTrig;
    strobe.runTimer = 1'b0;
    strobe.driving  = (state == ST_HOLD);
    stateNext       = state;
    if (strobe.clrTimer) begin
      stateNext = ST_HOLD;
    end else if (state == ST_HOLD) begin
      if (status.timerDone) stateNext = ST_IDLE;
      else                  strobe.runTimer = 1'b1;
    end
  end

  AST_UV_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    status.uvQual |=> (state == ST_HOLD)); // R2

  AST_TRIG_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    status.mrTrig |=> (state == ST_HOLD)); // R5

  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_HOLD) |-> $past(status.timerDone)); // R4

endmodule

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor
  import rsv_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 200,
  parameter int unsigned UV_FILTER      = 4,
  parameter int unsigned MR_FILTER      = 6,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic mrPinIn,
  output logic rstLowDrvEn,
  output logic rstHighDrvEn,
  output logic resetActive
);

  rsvStrobe_t strobe;
  rsvStatus_t status;

  rsv_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .UV_FILTER     (UV_FILTER),
    .MR_FILTER     (MR_FILTER),
    .SYNC_STAGES   (SYNC_STAGES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .supplyLow(supplyLow),
    .pinIn    (mrPinIn),
    .strobe   (strobe),
    .status   (status)
  );

  rsv_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .status(status),
    .strobe(strobe)
  );

  // R11: both polarities follow the same registered state
  assign rstLowDrvEn  = strobe.driving;
  assign rstHighDrvEn = strobe.driving;
  assign resetActive  = strobe.driving;

endmodule

// File: tb/supply_reset_supervisor_test.sv
module supply_reset_supervisor_test;

  localparam int CLK_PERIOD = 10;
  localparam int TO  = 200;
  localparam int UVF = 4;
  localparam int MRF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 1'b0;
  logic extLow = 1'b0;
  logic rstLowDrvEn, rstHighDrvEn, resetActive;
  logic pinLevel;

  // wired pin: pull-up, pulled low by the button or by the block
  assign pinLevel = ~(extLow | rstLowDrvEn);

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_supervisor #(
    .TIMEOUT_CYCLES(TO), .UV_FILTER(UVF), .MR_FILTER(MRF), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .mrPinIn(pinLevel),
    .rstLowDrvEn(rstLowDrvEn), .rstHighDrvEn(rstHighDrvEn),
    .resetActive(resetActive)
  );

  typedef struct {
    int    cyc;
    bit    exp;
    string tag;
  } item_t;

  item_t expQ[$];
  item_t cur;
  int cycNow = 0;
  int total = 0;
  int bad = 0;

  always @(posedge clk) cycNow <= cycNow + 1;

  task automatic expectAt(input int off, input bit v, input string tag);
    item_t it;
    it.cyc = cycNow + off;
    it.exp = v;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cycNow) begin
      cur = expQ.pop_front();
      total++;
      if (rstLowDrvEn !== resetActive || rstHighDrvEn !== resetActive) begin
        bad++;
        $display("FAIL R11 cycle %0d: lowEn=%0b highEn=%0b expected both %0b",
                 cycNow, rstLowDrvEn, rstHighDrvEn, resetActive);
      end else if (resetActive !== cur.exp) begin
        bad++;
        $display("FAIL %s cycle %0d: resetActive=%0b expected %0b",
                 cur.tag, cycNow, resetActive, cur.exp);
      end
    end
  end

  task automatic drain();
    wait (expQ.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    // R1: reset state and power-up timeout
    repeat (3) @(negedge clk);
    total++;
    if (resetActive !== 1'b1 || rstLowDrvEn !== 1'b1 || rstHighDrvEn !== 1'b1) begin
      bad++;
      $display("FAIL R1 in reset: active=%0b lowEn=%0b highEn=%0b expected 1",
               resetActive, rstLowDrvEn, rstHighDrvEn);
    end
    rstN = 1'b1;
    expectAt(TO - 1, 1'b1, "R1");
    expectAt(TO + 2, 1'b0, "R1");
    drain();

    // R3: supply glitch one cycle too short
    @(negedge clk);
    for (int i = 1; i <= UVF + 6; i++) expectAt(i, 1'b0, "R3");
    supplyLow = 1'b1;
    repeat (UVF - 1) @(negedge clk);
    supplyLow = 1'b0;
    drain();

    // R2 / R4: long supply low, then recovery timeout
    @(negedge clk);
    supplyLow = 1'b1;
    expectAt(UVF + 2, 1'b1, "R2");
    expectAt(2 * TO, 1'b1, "R2");
    repeat (3 * TO) @(negedge clk);
    supplyLow = 1'b0;
    expectAt(TO - 1, 1'b1, "R4");
    expectAt(TO + 2, 1'b0, "R4");
    drain();

    // R6: manual pulse one cycle too short
    @(negedge clk);
    for (int i = 1; i <= MRF + 8; i++) expectAt(i, 1'b0, "R6");
    extLow = 1'b1;
    repeat (MRF - 1) @(negedge clk);
    extLow = 1'b0;
    drain();

    // R5 / R7 / R9: short qualified pulse stretched, no self-retrigger
    @(negedge clk);
    extLow = 1'b1;
    expectAt(MRF + 4, 1'b1, "R5");
    expectAt(MRF + TO + 1, 1'b1, "R7");
    expectAt(MRF + TO + 5, 1'b0, "R7");
    for (int i = MRF + TO + 6; i <= MRF + TO + 40; i++) expectAt(i, 1'b0, "R9");
    repeat (MRF + 2) @(negedge clk);
    extLow = 1'b0;
    drain();

    // R8: pin held low past the timeout
    @(negedge clk);
    extLow = 1'b1;
    expectAt(MRF + 4, 1'b1, "R8");
    expectAt(MRF + TO + 5, 1'b0, "R8");
    expectAt(MRF + TO + 40, 1'b0, "R8");
    repeat (MRF + TO + 60) @(negedge clk);
    extLow = 1'b0;
    for (int i = 1; i <= MRF + 10; i++) expectAt(i, 1'b0, "R8");
    drain();

    // R10: supply dip in the middle of a manual timeout restarts it
    @(negedge clk);
    extLow = 1'b1;
    repeat (MRF + 2) @(negedge clk);
    extLow = 1'b0;
    repeat (TO / 2 - (MRF + 2)) @(negedge clk);
    supplyLow = 1'b1;
    repeat (UVF + 2) @(negedge clk);
    supplyLow = 1'b0;
    expectAt(TO - 1, 1'b1, "R10");
    expectAt(TO + 2, 1'b0, "R10");
    drain();

    finishRun();
  end

endmodule